// File: doc/BRIEF.md
# Fully Associative Address-Data Cache

This block is a small read cache organised as a content-addressable table. Each slot keeps a complete memory address beside the 12-bit word found at that address, plus a valid flag, so any address can live in any slot. A read request is compared against every occupied slot in the same cycle. When one of them matches, the stored word goes back to the requester one cycle later without touching memory.

When no slot matches, the block raises a single-word fetch towards the next memory level and waits for it. The fetched word is returned to the requester and the address-data pair is written into the table. While free slots remain, the lowest-numbered free slot is filled. Once the table is full, slots are overwritten in rotating order. Only one miss is outstanding at a time, and the block refuses new requests until the fetch has completed.

Top module: `assoc_cache`

## Requirements
- R1: After reset every slot is empty, `req_ready` is 1, and `rsp_valid` and `mem_req` are 0. The first request after reset is therefore a miss.
- R2: An accepted request whose address is held in a valid slot produces `rsp_valid`=1 and `rsp_hit`=1 in the next cycle. `rsp_data` carries the stored word and `mem_req` stays 0.
- R3: An accepted request that misses raises `mem_req` in the next cycle with `mem_addr` equal to the request address. Both hold unchanged until a cycle in which `mem_valid` is 1.
- R4: In the cycle after `mem_valid` is seen during a fetch, `rsp_valid`=1 and `rsp_hit`=0, with `rsp_data` equal to the `mem_data` that was sampled. The pair is installed, so the next request for that address hits.
- R5: `req_ready` is 0 from the cycle after a miss is accepted up to and including the fill cycle. Requests presented while `req_ready` is 0 produce no response and install nothing.
- R6: `mem_valid` while no fetch is outstanding has no effect: no response is produced and the table contents are unchanged.
- R7: While any slot is empty, a fill goes to the lowest-numbered empty slot.
- R8: When all slots are valid, a fill replaces the slot named by a rotating pointer. The pointer starts at slot 0 after reset, advances by one after each such replacement, and wraps from the last slot to slot 0.
- R9: No address is ever held in two valid slots, so at most one slot matches any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_addr | input | 15 | Requested address |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | Response word valid, one-cycle pulse |
| rsp_hit | output | 1 | Response was served from the table |
| rsp_data | output | 12 | Response word |
| mem_req | output | 1 | Fetch to next memory level outstanding |
| mem_addr | output | 15 | Address of the outstanding fetch |
| mem_valid | input | 1 | Fetched word present on mem_data |
| mem_data | input | 12 | Fetched word |

## Verification
A corrupted valid flag, stored address or rotating pointer does not show up at the moment it happens. It shows later, as a hit where a miss was due, a miss where a hit was due, or a wrong word. The bench therefore keeps its own model of the table and pointer and predicts hit or miss for every request, from a small address pool that forces repeated wrap-around replacement. A wrong placement or eviction order then appears within at most one full rotation of the table, that is within about eight fills. A bad fetch handshake shows up directly on `mem_req`, `mem_addr` and `req_ready` in the cycle after the request is accepted.

// File: rtl/assoc_cache_pkg.sv
package assoc_cache_pkg;
    localparam int DEF_ADDR_W  = 15;
    localparam int DEF_DATA_W  = 12;
    localparam int DEF_ENTRIES = 8;
endpackage

// File: rtl/assoc_match.sv
module assoc_match #(
    parameter int ADDR_W  = 15,
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ENTRIES-1:0]             slot_valid,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] slot_addr,
    input  logic [ADDR_W-1:0]              key,
    output logic [ENTRIES-1:0]             match,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = slot_valid[g] && (slot_addr[g] == key);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_idx = hit_idx | IDX_W'(i);
        end
    end

    assign hit = |match;

    assert_one_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match) <= 1);
endmodule

// File: rtl/assoc_victim.sv
module assoc_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] slot_valid,
    input  logic [IDX_W-1:0]   rr_ptr,
    output logic               full,
    output logic [IDX_W-1:0]   victim
);
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!slot_valid[i]) free_idx = IDX_W'(i);
        end
    end

    assign full   = &slot_valid;
    assign victim = full ? rr_ptr : free_idx;
endmodule

// File: rtl/assoc_cache.sv
module assoc_cache
    import assoc_cache_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int DATA_W  = DEF_DATA_W,
    parameter int ENTRIES = DEF_ENTRIES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_data
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][ADDR_W-1:0] addr;
        logic [ENTRIES-1:0][DATA_W-1:0] data;
        logic                           busy;
        logic [ADDR_W-1:0]              pend;
        logic [IDX_W-1:0]               rr;
        logic                           rsp_v;
        logic                           rsp_h;
        logic [DATA_W-1:0]              rsp_d;
    } state_t;

    state_t s_d, s_q;

    logic [ENTRIES-1:0] match_vec;
    logic               lk_hit;
    logic [IDX_W-1:0]   lk_idx;
    logic               tbl_full;
    logic [IDX_W-1:0]   victim;

    assoc_match #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) i_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_valid(s_q.valid),
        .slot_addr (s_q.addr),
        .key       (req_addr),
        .match     (match_vec),
        .hit       (lk_hit),
        .hit_idx   (lk_idx)
    );

    assoc_victim #(.ENTRIES(ENTRIES)) i_victim (
        .slot_valid(s_q.valid),
        .rr_ptr    (s_q.rr),
        .full      (tbl_full),
        .victim    (victim)
    );

    always_comb begin
        s_d       = s_q;
        s_d.rsp_v = 1'b0;
        s_d.rsp_h = 1'b0;
        if (!s_q.busy) begin
            if (req_valid) begin
                if (lk_hit) begin
                    s_d.rsp_v = 1'b1;
                    s_d.rsp_h = 1'b1;
                    s_d.rsp_d = s_q.data[lk_idx];
                end else begin
                    s_d.busy = 1'b1;
                    s_d.pend = req_addr;
                end
            end
        end else if (mem_valid) begin
            s_d.busy          = 1'b0;
            s_d.valid[victim] = 1'b1;
            s_d.addr[victim]  = s_q.pend;
            s_d.data[victim]  = mem_data;
            s_d.rsp_v         = 1'b1;
            s_d.rsp_d         = mem_data;
            if (tbl_full) begin
                s_d.rr = (s_q.rr == LAST) ? '0 : s_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready = !s_q.busy;
    assign mem_req   = s_q.busy;
    assign mem_addr  = s_q.pend;
    assign rsp_valid = s_q.rsp_v;
    assign rsp_hit   = s_q.rsp_h;
    assign rsp_data  = s_q.rsp_d;

    assert_fetch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_valid |=> mem_req && $stable(mem_addr));
    assert_fill_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_valid |=> rsp_valid && !rsp_hit && !mem_req);
    assert_busy_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);
    assert_hit_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && lk_hit |=> rsp_valid && rsp_hit && !mem_req);
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready && !req_valid |=> !rsp_valid && !mem_req);
    assert_victim_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_valid && !tbl_full |-> !s_q.valid[victim]);
endmodule

// File: tb/test_assoc_cache.sv
`timescale 1ns/1ps
module test_assoc_cache;
    localparam int AW = 15;
    localparam int DW = 12;
    localparam int N  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          rsp_valid, rsp_hit;
    logic [DW-1:0] rsp_data;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_valid = 1'b0;
    logic [DW-1:0] mem_data = '0;

    int checks = 0;
    int errors = 0;

    logic          m_v [N];
    logic [AW-1:0] m_a [N];
    int            m_rr;

    always #2.5 clk = ~clk;

    assoc_cache i_assoc_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_data(mem_data)
    );

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return a[11:0] ^ {4{a[14:12]}} ^ 12'h5A3;
    endfunction

    function automatic int model_find(input logic [AW-1:0] a);
        for (int i = 0; i < N; i++) if (m_v[i] && m_a[i] == a) return i;
        return -1;
    endfunction

    task automatic model_fill(input logic [AW-1:0] a);
        int slot;
        slot = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
        if (slot < 0) begin
            slot = m_rr;
            m_rr = (m_rr + 1) % N;
        end
        m_v[slot] = 1'b1;
        m_a[slot] = a;
    endtask

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic access(input logic [AW-1:0] a, input int lat, input logic intrude,
                          input logic [AW-1:0] other);
        logic exp_hit;
        exp_hit = model_find(a) >= 0;
        @(negedge clk);
        check(req_ready, "R5 ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = intrude;
        req_addr  = other;
        if (exp_hit) begin
            check(rsp_valid && rsp_hit, "R2 hit response", int'({rsp_valid, rsp_hit}), 3);
            check(rsp_data == memf(a), "R2 hit data", int'(rsp_data), int'(memf(a)));
            check(!mem_req, "R2 no fetch on hit", int'(mem_req), 0);
            req_valid = 1'b0;
        end else begin
            check(mem_req && mem_addr == a, "R3 fetch address", int'(mem_addr), int'(a));
            check(!rsp_valid && !req_ready, "R5 busy after miss",
                  int'({rsp_valid, req_ready}), 0);
            for (int k = 1; k < lat; k++) begin
                @(negedge clk);
                check(mem_req && mem_addr == a && !req_ready, "R3 fetch held",
                      int'(mem_addr), int'(a));
            end
            mem_valid = 1'b1;
            mem_data  = memf(a);
            @(negedge clk);
            mem_valid = 1'b0;
            req_valid = 1'b0;
            check(rsp_valid && !rsp_hit, "R4 fill response", int'({rsp_valid, rsp_hit}), 2);
            check(rsp_data == memf(a), "R4 fill data", int'(rsp_data), int'(memf(a)));
            check(!mem_req && req_ready, "R5 ready after fill", int'(req_ready), 1);
            model_fill(a);
            @(negedge clk);
            check(!rsp_valid && !mem_req, "R5 intruding request ignored",
                  int'({rsp_valid, mem_req}), 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] pool [12];
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        m_rr = 0;
        for (int i = 0; i < 12; i++) pool[i] = AW'(15'h0111 * (i + 1) + 15'h2003 * i);

        repeat (3) @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req, "R1 reset outputs",
              int'({req_ready, rsp_valid, mem_req}), 4);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: stray fill strobe while idle
        mem_valid = 1'b1;
        mem_data  = 12'hFFF;
        @(negedge clk);
        mem_valid = 1'b0;
        check(!rsp_valid && !mem_req, "R6 stray mem_valid", int'(rsp_valid), 0);
        @(negedge clk);
        check(!rsp_valid, "R6 stray mem_valid late", int'(rsp_valid), 0);

        // R1 first access misses; R7 fill order; R5 intruding request
        for (int i = 0; i < N; i++) access(pool[i], 1 + (i % 3), i == 2, pool[9]);
        // R9 every installed address hits once
        for (int i = 0; i < N; i++) access(pool[i], 1, 1'b0, '0);
        // R5 intruder pool[9] must not be installed; R8 evicts slot 0
        access(pool[9], 2, 1'b0, '0);
        access(pool[0], 1, 1'b0, '0);
        access(pool[2], 1, 1'b0, '0);
        access(pool[1], 3, 1'b0, '0);
        access(pool[9], 1, 1'b0, '0);

        // R8/R9 random mix over a pool larger than the table
        for (int n = 0; n < 400; n++) begin
            int pick, lat;
            pick = int'($urandom_range(11, 0));
            lat  = int'($urandom_range(4, 1));
            access(pool[pick], lat, ($urandom_range(3, 0) == 0),
                   pool[$urandom_range(11, 0)]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule